// File: doc/BRIEF.md
# Interrupt Request Flag Controller

This block keeps the pending-request flags for a small interrupt system. It serves two active-low external interrupt pins, two timer overflow pulses and one timer-reload event. Each external pin has its own type bit, which selects low-level sensing or falling-edge sensing. Each flag is masked by its own enable bit and by a global enable bit. The result is registered and presented as one request line per source to a downstream priority and vector stage.

That downstream stage returns a one-cycle acknowledge per source when it vectors to a handler. Edge-sensed flags and pulse-set flags are cleared by that acknowledge. A level-sensed flag simply tracks its synchronized pin, so it is never cleared by an acknowledge. Software reads and writes the flag, enable and type registers through a plain single-cycle register port. The reload event itself is forwarded unchanged, so the timer that consumes it never depends on the interrupt enables.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, all flags, all enables and the global enable are 0, and both type bits are 0 (level mode). irq_o is 0.
- R2: In level mode (type bit 0), an external flag is 1 exactly while its synchronized pin is low. The flag changes on the third rising clock edge after the pin changes, and the request output changes on the fourth.
- R3: An acknowledge for a level-mode external source leaves its flag set while the pin stays low. A software write to that flag has no effect.
- R4: In edge mode (type bit 1), an external flag is set by a 1-to-0 transition of the synchronized pin. Holding the pin low or raising it does not set the flag again.
- R5: In edge mode, an acknowledge for that source clears its flag on the acknowledging clock edge.
- R6: A one-cycle timer overflow pulse sets that timer's flag, and the acknowledge for that source clears it.
- R7: When a hardware set and an acknowledge arrive for a flag in the same cycle, the flag ends up set.
- R8: A source whose enable bit is 0 never drives its irq_o bit. Its flag is still set and can be read back.
- R9: While the global enable (bit 7 of the enable register) is 0, irq_o is all zero whatever the flags and per-source enables.
- R10: The reload event sets the reload flag, and that flag is gated by its own enable. rld_evt_o follows rld_evt_i combinationally whatever the enable holds.
- R11: A write to the flag register loads the edge-mode and pulse-set flags on that same clock edge.
- R12: Register map on addr_i: 0 = flags, 1 = enables, 2 = types, 3 reads 0. In the flag and enable registers, bit 0 is external 0, bit 1 external 1, bit 2 timer 0, bit 3 timer 1 and bit 4 reload. The enable register adds the global enable at bit 7. In the type register, bits 1:0 select the external pins. Unimplemented bits read 0.
- R13: irq_o bit i is the registered AND of flag i, enable i and the global enable, and it appears one cycle after those values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_n_i | input | 2 | External interrupt pins, active low, asynchronous |
| tmr_ovf_i | input | 2 | Timer overflow pulses, one cycle each |
| rld_evt_i | input | 1 | Timer reload event pulse |
| rld_evt_o | output | 1 | Reload event forwarded to the timer |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select for read and write |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data, combinational from addr_i |
| ack_i | input | 5 | Per-source acknowledge from the vector stage |
| irq_o | output | 5 | Registered, masked request per source |

## Verification
The assertions take it for granted that an acknowledge is a single-cycle pulse, that it is raised only for a source that was requesting, and that the timer and reload inputs are one-cycle pulses synchronous to the clock. The bench drives every input at the falling clock edge. It raises each acknowledge for exactly one cycle. It moves the external pins only after they have stayed at one level long enough to pass the synchronizer. The acknowledge-clear properties also assume that no software write or hardware set falls in the same cycle unless that overlap is the case under test.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned GEN_BIT = 7;

  typedef enum logic [1:0] {
    ADDR_FLAG = 2'd0,
    ADDR_EN   = 2'd1,
    ADDR_TYPE = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_ext_flag.sv
module irq_ext_flag #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_n_i,
  input  logic edge_mode_i,
  input  logic wr_i,
  input  logic wr_val_i,
  input  logic ack_i,
  output logic flag_o
);
  logic pin_s, prev_q, fall, flag_q;

  irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_n_i),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= pin_s;
  end

  assign fall = prev_q & ~pin_s;

  // level mode: flag tracks the pin, writes and acks ignored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           flag_q <= 1'b0;
    else if (!edge_mode_i) flag_q <= ~pin_s;
    else if (fall)         flag_q <= 1'b1;
    else if (wr_i)         flag_q <= wr_val_i;
    else if (ack_i)        flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_edge_ack_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && ack_i && !fall && !wr_i) |=> !flag_o);

  p_level_ack_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && ack_i && !pin_s) |=> flag_o);

  p_edge_fall_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && $fell(pin_s)) |=> flag_o);
endmodule

// File: rtl/irq_pulse_flag.sv
module irq_pulse_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wr_i,
  input  logic wr_val_i,
  input  logic ack_i,
  output logic flag_o
);
  logic flag_q;

  // hardware set dominates write, write dominates ack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (wr_i)  flag_q <= wr_val_i;
    else if (ack_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);

  p_ack_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set_i && !wr_i) |=> !flag_o);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int unsigned N_EXT       = 2,
  parameter int unsigned N_TMR       = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NSRC       = N_EXT + N_TMR + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] ext_n_i,
  input  logic [N_TMR-1:0] tmr_ovf_i,
  input  logic             rld_evt_i,
  output logic             rld_evt_o,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic [NSRC-1:0]  ack_i,
  output logic [NSRC-1:0]  irq_o
);
  localparam int unsigned TMR_LO = N_EXT;
  localparam int unsigned RLD_IX = N_EXT + N_TMR;

  logic [NSRC-1:0]  flags, en_q, irq_q;
  logic [N_EXT-1:0] type_q;
  logic             gen_q;
  logic             wr_flag, wr_en_reg, wr_type;
  reg_addr_e        addr;

  assign addr      = reg_addr_e'(addr_i);
  assign wr_flag   = wr_en_i && (addr == ADDR_FLAG);
  assign wr_en_reg = wr_en_i && (addr == ADDR_EN);
  assign wr_type   = wr_en_i && (addr == ADDR_TYPE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      gen_q  <= 1'b0;
      type_q <= '0;
    end else begin
      if (wr_en_reg) begin
        en_q  <= wr_data_i[NSRC-1:0];
        gen_q <= wr_data_i[GEN_BIT];
      end
      if (wr_type) type_q <= wr_data_i[N_EXT-1:0];
    end
  end

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    irq_ext_flag #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_n_i    (ext_n_i[i]),
      .edge_mode_i(type_q[i]),
      .wr_i       (wr_flag),
      .wr_val_i   (wr_data_i[i]),
      .ack_i      (ack_i[i]),
      .flag_o     (flags[i])
    );
  end

  for (genvar j = 0; j < N_TMR; j++) begin : g_tmr
    irq_pulse_flag u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (tmr_ovf_i[j]),
      .wr_i    (wr_flag),
      .wr_val_i(wr_data_i[TMR_LO+j]),
      .ack_i   (ack_i[TMR_LO+j]),
      .flag_o  (flags[TMR_LO+j])
    );
  end

  irq_pulse_flag u_rld (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (rld_evt_i),
    .wr_i    (wr_flag),
    .wr_val_i(wr_data_i[RLD_IX]),
    .ack_i   (ack_i[RLD_IX]),
    .flag_o  (flags[RLD_IX])
  );

  // reload event never depends on the enables
  assign rld_evt_o = rld_evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= flags & en_q & {NSRC{gen_q}};
  end

  assign irq_o = irq_q;

  always_comb begin
    rd_data_o = '0;
    unique case (addr)
      ADDR_FLAG: rd_data_o[NSRC-1:0] = flags;
      ADDR_EN: begin
        rd_data_o[NSRC-1:0] = en_q;
        rd_data_o[GEN_BIT]  = gen_q;
      end
      ADDR_TYPE: rd_data_o[N_EXT-1:0] = type_q;
      default:   rd_data_o = '0;
    endcase
  end

  p_global_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_q |=> (irq_o == '0));

  p_enable_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irq_o & ~$past(en_q)) == '0));

  p_irq_needs_flag_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irq_o & ~$past(flags)) == '0));
endmodule

// File: tb/irq_flag_ctrl_test.sv
`timescale 1ns/1ps
module irq_flag_ctrl_test;
  localparam time CLK_P = 20ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] ext_n_i = 2'b11;
  logic [1:0] tmr_ovf_i = '0;
  logic       rld_evt_i = 1'b0;
  logic       rld_evt_o;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic [4:0] ack_i = '0;
  logic [4:0] irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  irq_flag_ctrl uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ext_n_i  (ext_n_i),
    .tmr_ovf_i(tmr_ovf_i),
    .rld_evt_i(rld_evt_i),
    .rld_evt_o(rld_evt_o),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o),
    .ack_i    (ack_i),
    .irq_o    (irq_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    tick(1);
    wr_en_i = 1'b0; addr_i = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a; #1; d = rd_data_o; addr_i = 2'd0;
  endtask

  task automatic ack(input logic [4:0] v);
    ack_i = v; tick(1); ack_i = '0;
  endtask

  task automatic flags_is(input string req, input logic [7:0] exp);
    logic [7:0] d;
    rd(2'd0, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    flags_is("R1 flags", 8'h00);
    rd(2'd1, d); check("R1 enables", d, 8'h00);
    rd(2'd2, d); check("R1 types", d, 8'h00);
    check("R1 irq", {3'b0, irq_o}, 8'h00);
  endtask

  task automatic t_level;
    wr(2'd1, 8'h9F);
    ext_n_i[0] = 1'b0;
    tick(2); flags_is("R2 not before 3rd edge", 8'h00);
    tick(1); flags_is("R2 flag after sync", 8'h01);
    check("R2 irq one later", {3'b0, irq_o}, 8'h00);
    tick(1); check("R2 irq", {3'b0, irq_o}, 8'h01);
    ack(5'b00001);
    flags_is("R3 ack keeps level flag", 8'h01);
    wr(2'd0, 8'h00);
    flags_is("R3 write ignored in level mode", 8'h01);
    ext_n_i[0] = 1'b1;
    tick(3); flags_is("R2 flag follows pin high", 8'h00);
    tick(1); check("R2 irq drops", {3'b0, irq_o}, 8'h00);
  endtask

  task automatic t_edge;
    wr(2'd2, 8'h01);
    tick(2);
    flags_is("R4 no flag on mode change", 8'h00);
    ext_n_i[0] = 1'b0;
    tick(3); flags_is("R4 fall sets flag", 8'h01);
    tick(3);
    ack(5'b00001);
    flags_is("R5 ack clears edge flag", 8'h00);
    tick(4); flags_is("R4 held low no retrigger", 8'h00);
    ext_n_i[0] = 1'b1;
    tick(4); flags_is("R4 rise no set", 8'h00);
    ext_n_i[0] = 1'b0;
    tick(3); flags_is("R4 second fall", 8'h01);
    ack(5'b00001);
    flags_is("R5 second clear", 8'h00);
    ext_n_i[0] = 1'b1;
    tick(4);
  endtask

  task automatic t_timer;
    tmr_ovf_i[0] = 1'b1; tick(1); tmr_ovf_i[0] = 1'b0;
    flags_is("R6 pulse sets", 8'h04);
    tick(1); check("R13 irq follows flag", {3'b0, irq_o}, 8'h04);
    ack(5'b00100);
    flags_is("R6 ack clears", 8'h00);
    tick(1); check("R13 irq clears", {3'b0, irq_o}, 8'h00);
  endtask

  task automatic t_set_wins;
    tmr_ovf_i[1] = 1'b1; ack_i = 5'b01000;
    tick(1);
    tmr_ovf_i[1] = 1'b0; ack_i = '0;
    flags_is("R7 set beats ack", 8'h08);
    ack(5'b01000);
    flags_is("R7 cleanup", 8'h00);
  endtask

  task automatic t_enable;
    wr(2'd1, 8'h80);
    tmr_ovf_i[0] = 1'b1; tick(1); tmr_ovf_i[0] = 1'b0;
    tick(2);
    check("R8 disabled no irq", {3'b0, irq_o}, 8'h00);
    flags_is("R8 flag still set", 8'h04);
    wr(2'd1, 8'h84);
    tick(1); check("R8 enabled irq", {3'b0, irq_o}, 8'h04);
    ack(5'b00100);
  endtask

  task automatic t_global;
    wr(2'd1, 8'h1F);
    tmr_ovf_i[1] = 1'b1; tick(1); tmr_ovf_i[1] = 1'b0;
    tick(2);
    check("R9 global off masks", {3'b0, irq_o}, 8'h00);
    wr(2'd1, 8'h9F);
    tick(1); check("R9 global on", {3'b0, irq_o}, 8'h08);
    ack(5'b01000);
  endtask

  task automatic t_reload;
    wr(2'd1, 8'h80);
    rld_evt_i = 1'b1; #1;
    check("R10 reload passes while disabled", {7'b0, rld_evt_o}, 8'h01);
    tick(1); rld_evt_i = 1'b0; #1;
    check("R10 reload passthrough low", {7'b0, rld_evt_o}, 8'h00);
    flags_is("R10 reload flag set", 8'h10);
    tick(1); check("R10 gated", {3'b0, irq_o}, 8'h00);
    wr(2'd1, 8'h90);
    tick(1); check("R10 enabled", {3'b0, irq_o}, 8'h10);
    ack(5'b10000);
    flags_is("R10 ack clears", 8'h00);
  endtask

  task automatic t_sw_write;
    wr(2'd0, 8'h1F);
    flags_is("R11 write loads edge and pulse flags", 8'h1D);
    wr(2'd0, 8'h00);
    flags_is("R11 write clears", 8'h00);
  endtask

  task automatic t_regmap;
    logic [7:0] d;
    wr(2'd2, 8'hFF);
    rd(2'd2, d); check("R12 type width", d, 8'h03);
    wr(2'd1, 8'hFF);
    rd(2'd1, d); check("R12 enable bits", d, 8'h9F);
    rd(2'd3, d); check("R12 addr 3 zero", d, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    t_reset();
    t_level();
    t_edge();
    t_timer();
    t_set_wins();
    t_enable();
    t_global();
    t_reload();
    t_sw_write();
    t_regmap();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule